// File: doc/BRIEF.md
# Serial EEPROM Word-Write Controller

This block sits between a host register bus and a small three-wire serial EEPROM organised as 16-bit words. The host does not handle the serial protocol. It writes a word address and two data bytes into holding registers, then writes a one-hot command code into a control register. The codes are: allow writes, write one word, and forbid writes. The block builds the matching serial frame, shifts it out on chip select, serial clock and data-in, and then polls the device's data-out line until the device has finished programming.

While any of this is in progress a busy bit reads 1 and further commands are dropped. The host therefore polls busy between steps. A word write issued while the block's write-enable latch is clear never reaches the pins and fails at once. A write whose device never signals ready within a parameterised window also fails. A later successful write clears the failure bit.

Top module: `eectl_top`

## Requirements
- R1: After reset the status register reads 0x00 and chip select, serial clock and data-in are all low.
- R2: Register offset 0 is control/status: writes carry command codes, and reads return busy in bit 0, the write-failure flag in bit 1 and the write-enable latch in bit 2. Offset 1 holds the word address (its low ADDR_W bits are used). Offset 2 holds the low data byte and offset 3 the high data byte. Offsets 1 to 3 read back what was written.
- R3: Code 0x01 sends a frame made of a start bit 1, opcode 00 and an address field whose top two bits are 11 and whose other bits are 0. The write-enable latch is set on the cycle busy drops.
- R4: Code 0x04 sends start 1, opcode 00 and an all-zero address field. The write-enable latch is cleared on the cycle busy drops.
- R5: Code 0x02, with the latch set, sends start 1, opcode 01, the ADDR_W address bits and then the 16 data bits, MSB first with the high byte first. Data-in changes only while the serial clock is low, and the serial clock pulses only while chip select is high.
- R6: Busy reads 1 on the cycle after the edge that accepts a command. For a word write it stays 1 until the device has reported ready or the poll has timed out.
- R7: Code 0x02 with the latch clear sets the failure flag. Busy stays 0 and chip select stays low.
- R8: After a write frame, chip select is held low for at least 2*CLK_DIV cycles, then raised while data-out is polled. Data-out high ends the write and clears the failure flag.
- R9: If data-out stays low for TIMEOUT_CYC poll cycles, the failure flag is set, chip select drops and busy then clears.
- R10: A command written while busy is 1 has no effect, and a code other than 0x01, 0x02 or 0x04 has no effect.
- R11: The address and data sent are those held at launch. Register writes made while busy do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to EEPROM |
| ee_do | input | 1 | Serial data / ready from EEPROM |

## Verification
Two activities can share a cycle in this block. The host can update the address, data or control registers while the sequencer is shifting or polling the frame of an earlier word write. The bench provokes this by launching a write, then issuing a write-disable code and rewriting all three holding registers while busy is 1. A scoreboard compares the word that the bench's device model actually assembled against the word queued at launch. The status read after busy drops must still show the write-enable latch set. The data register must read back the new byte.

// File: rtl/eectl_pkg.sv
package eectl_pkg;

   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_WREN  = 2'd1,
      OPK_WRITE = 2'd2,
      OPK_WRDIS = 2'd3
   } op_kind_t;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_SHIFT = 3'd1,
      S_GAP   = 3'd2,
      S_POLL  = 3'd3,
      S_TAIL  = 3'd4
   } seq_st_t;

   localparam logic [7:0] CODE_WREN  = 8'h01;
   localparam logic [7:0] CODE_WRITE = 8'h02;
   localparam logic [7:0] CODE_WRDIS = 8'h04;

   localparam logic [1:0] OFS_CTRL = 2'd0;
   localparam logic [1:0] OFS_ADDR = 2'd1;
   localparam logic [1:0] OFS_DLO  = 2'd2;
   localparam logic [1:0] OFS_DHI  = 2'd3;

   localparam int HDR_W  = 3;   // start bit plus two opcode bits
   localparam int WORD_W = 16;

endpackage

// File: rtl/eectl_regs.sv
module eectl_regs
   import eectl_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              busy,
   input  logic              res_valid,
   input  op_kind_t          res_kind,
   input  logic              res_ok,
   output logic              launch,
   output op_kind_t          launch_kind,
   output logic              wen,
   output logic [ADDR_W-1:0] word_addr,
   output logic [WORD_W-1:0] word_data
);

   logic [7:0] addr_q, dlo_q, dhi_q;
   logic       wen_q, fail_q;
   logic       cmd_sel, blocked;
   op_kind_t   cmd_kind;

   always_comb begin
      case (reg_wdata)
         CODE_WREN:  cmd_kind = OPK_WREN;
         CODE_WRITE: cmd_kind = OPK_WRITE;
         CODE_WRDIS: cmd_kind = OPK_WRDIS;
         default:    cmd_kind = OPK_NONE;
      endcase
   end

   assign cmd_sel     = reg_wr && (reg_addr == OFS_CTRL) && !busy;
   assign launch      = cmd_sel && ((cmd_kind == OPK_WREN) || (cmd_kind == OPK_WRDIS) ||
                                    ((cmd_kind == OPK_WRITE) && wen_q));
   assign blocked     = cmd_sel && (cmd_kind == OPK_WRITE) && !wen_q;
   assign launch_kind = cmd_kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         dlo_q  <= '0;
         dhi_q  <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            OFS_ADDR: addr_q <= reg_wdata;
            OFS_DLO:  dlo_q  <= reg_wdata;
            OFS_DHI:  dhi_q  <= reg_wdata;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q  <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         if (blocked)
            fail_q <= 1'b1;
         else if (res_valid && (res_kind == OPK_WRITE))
            fail_q <= !res_ok;
         if (res_valid && (res_kind == OPK_WREN))
            wen_q <= 1'b1;
         else if (res_valid && (res_kind == OPK_WRDIS))
            wen_q <= 1'b0;
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_CTRL: reg_rdata = {5'b0, wen_q, fail_q, busy};
         OFS_ADDR: reg_rdata = addr_q;
         OFS_DLO:  reg_rdata = dlo_q;
         default:  reg_rdata = dhi_q;
      endcase
   end

   assign wen       = wen_q;
   assign word_addr = addr_q[ADDR_W-1:0];
   assign word_data = {dhi_q, dlo_q};

   // R9: a timed-out or failed write leaves the failure flag set
   assert_fail_on_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_kind == OPK_WRITE) && !res_ok) |=> fail_q);

endmodule

// File: rtl/eectl_shift.sv
module eectl_shift #(
   parameter int FRAME_W = 25,
   parameter int CLK_DIV = 50,
   parameter int NB_W    = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [NB_W-1:0]    nbits,
   output logic               ee_sk,
   output logic               ee_di,
   output logic               done
);

   localparam int DIV_W = $clog2(CLK_DIV + 1);

   logic [FRAME_W-1:0] sreg;
   logic [NB_W-1:0]    left;
   logic [DIV_W-1:0]   hcnt;
   logic               sk_q, act;
   logic               half_end;

   assign half_end = (hcnt == DIV_W'(CLK_DIV - 1));
   assign done     = act && half_end && sk_q && (left == NB_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
         hcnt <= '0;
         sk_q <= 1'b0;
         act  <= 1'b0;
      end else if (load) begin
         sreg <= frame;
         left <= nbits;
         hcnt <= '0;
         sk_q <= 1'b0;
         act  <= 1'b1;
      end else if (act) begin
         if (half_end) begin
            hcnt <= '0;
            if (!sk_q) begin
               sk_q <= 1'b1;
            end else begin
               sk_q <= 1'b0;
               sreg <= sreg << 1;
               left <= left - NB_W'(1);
               if (left == NB_W'(1))
                  act <= 1'b0;
            end
         end else begin
            hcnt <= hcnt + DIV_W'(1);
         end
      end
   end

   assign ee_sk = sk_q;
   assign ee_di = act & sreg[FRAME_W-1];

   // R5: data-in holds while the serial clock is high
   assert_di_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ee_sk) && ee_sk) |-> $stable(ee_di));

endmodule

// File: rtl/eectl_seq.sv
module eectl_seq
   import eectl_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int CLK_DIV     = 50,
   parameter int TIMEOUT_CYC = 2500000,
   parameter int FRAME_W     = HDR_W + ADDR_W + WORD_W,
   parameter int NB_W        = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  op_kind_t           launch_kind,
   input  logic [ADDR_W-1:0]  word_addr,
   input  logic [WORD_W-1:0]  word_data,
   input  logic               sh_done,
   input  logic               do_ready,
   output logic               sh_load,
   output logic [FRAME_W-1:0] sh_frame,
   output logic [NB_W-1:0]    sh_nbits,
   output logic               ee_cs,
   output logic               busy,
   output logic               res_valid,
   output op_kind_t           res_kind,
   output logic               res_ok
);

   localparam int CMD_W   = HDR_W + ADDR_W;
   localparam int GAP_CYC = 2 * CLK_DIV;
   localparam int GAP_W   = $clog2(GAP_CYC + 1);
   localparam int TMO_W   = $clog2(TIMEOUT_CYC + 1);

   seq_st_t          st;
   op_kind_t         kind;
   logic             cs_q;
   logic [GAP_W-1:0] gcnt;
   logic [TMO_W-1:0] tmr;
   logic             gap_end, tmo;

   assign gap_end = (gcnt == GAP_W'(GAP_CYC - 1));
   assign tmo     = (tmr == TMO_W'(TIMEOUT_CYC - 1));

   always_comb begin
      sh_frame = '0;
      sh_nbits = NB_W'(CMD_W);
      case (launch_kind)
         OPK_WREN:
            sh_frame[FRAME_W-1 -: CMD_W] = {3'b100, 2'b11, {(ADDR_W-2){1'b0}}};
         OPK_WRITE: begin
            sh_frame = {3'b101, word_addr, word_data};
            sh_nbits = NB_W'(FRAME_W);
         end
         default:
            sh_frame[FRAME_W-1 -: CMD_W] = {3'b100, {ADDR_W{1'b0}}};
      endcase
   end

   assign sh_load = (st == S_IDLE) && launch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         kind <= OPK_NONE;
         cs_q <= 1'b0;
         gcnt <= '0;
         tmr  <= '0;
      end else begin
         case (st)
            S_IDLE:
               if (launch) begin
                  st   <= S_SHIFT;
                  cs_q <= 1'b1;
                  kind <= launch_kind;
               end
            S_SHIFT:
               if (sh_done) begin
                  st   <= S_GAP;
                  cs_q <= 1'b0;
                  gcnt <= '0;
               end
            S_GAP:
               if (gap_end) begin
                  gcnt <= '0;
                  if (kind == OPK_WRITE) begin
                     st   <= S_POLL;
                     cs_q <= 1'b1;
                     tmr  <= '0;
                  end else begin
                     st <= S_IDLE;
                  end
               end else begin
                  gcnt <= gcnt + GAP_W'(1);
               end
            S_POLL:
               if (do_ready || tmo) begin
                  st   <= S_TAIL;
                  cs_q <= 1'b0;
                  gcnt <= '0;
               end else begin
                  tmr <= tmr + TMO_W'(1);
               end
            S_TAIL:
               if (gap_end) st <= S_IDLE;
               else         gcnt <= gcnt + GAP_W'(1);
            default: st <= S_IDLE;
         endcase
      end
   end

   assign ee_cs     = cs_q;
   assign busy      = (st != S_IDLE);
   assign res_kind  = kind;
   assign res_ok    = (st == S_POLL) ? do_ready : 1'b1;
   assign res_valid = ((st == S_GAP) && gap_end && (kind != OPK_WRITE)) ||
                      ((st == S_POLL) && (do_ready || tmo));

   // R8: the poll phase is only entered after the low gap that follows a write frame
   assert_poll_after_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_POLL) && ($past(st) != S_POLL)) |-> ($past(st) == S_GAP) && !$past(cs_q));

endmodule

// File: rtl/eectl_top.sv
module eectl_top
   import eectl_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int CLK_DIV     = 50,
   parameter int TIMEOUT_CYC = 2500000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_wr,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       ee_cs,
   output logic       ee_sk,
   output logic       ee_di,
   input  logic       ee_do
);

   localparam int FRAME_W = HDR_W + ADDR_W + WORD_W;
   localparam int NB_W    = $clog2(FRAME_W + 1);

   if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr_w
      $error("eectl_top: ADDR_W must lie in 4..8");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("eectl_top: CLK_DIV must be at least 1");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("eectl_top: TIMEOUT_CYC must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("eectl_top: SYNC_STAGES must lie in 0..4");
   end

   logic               busy, launch, wen, res_valid, res_ok;
   logic               sh_load, sh_done, do_ready;
   op_kind_t           launch_kind, res_kind;
   logic [ADDR_W-1:0]  word_addr;
   logic [WORD_W-1:0]  word_data;
   logic [FRAME_W-1:0] sh_frame;
   logic [NB_W-1:0]    sh_nbits;

   if (SYNC_STAGES == 0) begin : g_no_sync
      assign do_ready = ee_do;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sync_q[i] <= 1'b0;
            else if (i == 0) sync_q[i] <= ee_do;
            else            sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
         end
      end
      assign do_ready = sync_q[SYNC_STAGES-1];
   end

   eectl_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .busy, .res_valid, .res_kind, .res_ok,
      .launch, .launch_kind, .wen, .word_addr, .word_data
   );

   eectl_seq #(
      .ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV), .TIMEOUT_CYC(TIMEOUT_CYC),
      .FRAME_W(FRAME_W), .NB_W(NB_W)
   ) u_seq (
      .clk, .rst_n, .launch, .launch_kind, .word_addr, .word_data,
      .sh_done, .do_ready, .sh_load, .sh_frame, .sh_nbits,
      .ee_cs, .busy, .res_valid, .res_kind, .res_ok
   );

   eectl_shift #(.FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV), .NB_W(NB_W)) u_shift (
      .clk, .rst_n, .load(sh_load), .frame(sh_frame), .nbits(sh_nbits),
      .ee_sk, .ee_di, .done(sh_done)
   );

   // R5: serial clock pulses only inside a chip-select window
   assert_sk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs);

   // R6: every chip-select rise happens while busy
   assert_cs_rise_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) |-> busy);

   // R7: a write with the enable latch clear never starts a frame
   assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == OFS_CTRL) && (reg_wdata == CODE_WRITE) && !busy && !wen)
      |=> (!busy && !ee_cs));

endmodule

// File: tb/sim_eectl_top.sv
module sim_eectl_top;

   localparam int AW   = 6;
   localparam int DIV  = 2;
   localparam int TMO  = 3000;
   localparam int PROG = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       ee_cs, ee_sk, ee_di, ee_do;

   always #2 clk = ~clk;

   eectl_top #(.ADDR_W(AW), .CLK_DIV(DIV), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u0 (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .ee_cs, .ee_sk, .ee_di, .ee_do
   );

   // ---------------- device model ----------------
   logic [31:0] d_sr = '0;
   int          d_bits = 0;
   logic        d_wen = 1'b0;
   int          d_prog = 0;
   logic        d_hang = 1'b0;
   logic        d_commit = 1'b0;
   logic [21:0] d_word = '0;
   logic        sk_p = 1'b0, cs_p = 1'b0;
   int          low_cnt = 0, gap_seen = 0, cs_rises = 0;
   logic        last_write = 1'b0;

   assign ee_do = ee_cs && (d_bits == 0) && (d_prog == 0) && !d_hang;

   always @(negedge clk) begin
      d_commit = 1'b0;
      if (d_prog > 0) d_prog = d_prog - 1;
      if (ee_cs && !cs_p) begin
         cs_rises = cs_rises + 1;
         if (last_write) gap_seen = low_cnt;
         d_bits = 0;
      end
      if (cs_p && !ee_cs) begin
         low_cnt = 0;
         last_write = 1'b0;
         if (d_bits == 3 + AW && d_sr[AW+2:AW] == 3'b100) begin
            if (d_sr[AW-1:AW-2] == 2'b11) d_wen = 1'b1;
            else if (d_sr[AW-1:AW-2] == 2'b00) d_wen = 1'b0;
         end else if (d_bits == 19 + AW && d_sr[AW+18:AW+16] == 3'b101) begin
            last_write = 1'b1;
            if (d_wen) begin
               d_word   = d_sr[AW+15:0];
               d_commit = 1'b1;
               d_prog   = PROG;
            end
         end
      end
      if (!ee_cs) low_cnt = low_cnt + 1;
      if (ee_cs && ee_sk && !sk_p) begin
         d_sr   = {d_sr[30:0], ee_di};
         d_bits = d_bits + 1;
      end
      sk_p = ee_sk;
      cs_p = ee_cs;
   end

   // ---------------- scoreboard ----------------
   int          n_chk = 0, n_bad = 0;
   logic [21:0] exp_q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_word(input logic [AW-1:0] a, input logic [15:0] d);
      exp_q.push_back({a, d});
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_idle(output int cyc);
      logic [7:0] s;
      cyc = 0;
      rd(2'd0, s);
      while (s[0] && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         rd(2'd0, s);
      end
   endtask

   initial begin
      logic [7:0] v;
      int         cyc, r0;
      fork
         forever begin
            @(posedge clk);
            if (d_commit) begin
               if (exp_q.size() == 0) begin
                  chk("R5 unexpected word", {10'd0, d_word}, 32'hFFFFFFFF);
               end else begin
                  chk("R5/R11 word on pins", {10'd0, d_word}, {10'd0, exp_q.pop_front()});
               end
            end
         end
      join_none
      fork
         begin
            repeat (5) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1 reset state
            rd(2'd0, v); chk("R1 status", v, 8'h00);
            chk("R1 pins", {ee_cs, ee_sk, ee_di}, 3'b000);
            // R2 holding registers
            wr(2'd1, 8'h05); wr(2'd2, 8'h5A); wr(2'd3, 8'hA5);
            rd(2'd1, v); chk("R2 addr reg", v, 8'h05);
            rd(2'd2, v); chk("R2 low byte", v, 8'h5A);
            rd(2'd3, v); chk("R2 high byte", v, 8'hA5);
            // R7 write while latch clear
            r0 = cs_rises;
            wr(2'd0, 8'h02);
            rd(2'd0, v); chk("R7 blocked status", v, 8'h02);
            repeat (20) @(negedge clk);
            chk("R7 no frame", cs_rises, r0);
            // R3 write enable
            wr(2'd0, 8'h01);
            rd(2'd0, v); chk("R6 busy after enable code", v[0], 1'b1);
            wait_idle(cyc);
            rd(2'd0, v); chk("R3 latch set", v, 8'h06);
            chk("R3 device enabled", d_wen, 1'b1);
            // R5 R6 R8 word write
            expect_word(6'd5, 16'hA55A);
            wr(2'd0, 8'h02);
            wait_idle(cyc);
            chk("R6 busy covers programming", cyc >= PROG, 1'b1);
            rd(2'd0, v); chk("R8 success clears fail", v, 8'h04);
            chk("R8 cs low gap", gap_seen >= 2 * DIV, 1'b1);
            // R10 R11 register traffic during a write
            wr(2'd1, 8'h3F); wr(2'd2, 8'h01); wr(2'd3, 8'h00);
            expect_word(6'd63, 16'h0001);
            wr(2'd0, 8'h02);
            repeat (5) @(negedge clk);
            wr(2'd0, 8'h04);
            wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'h00);
            wait_idle(cyc);
            rd(2'd0, v); chk("R10 disable while busy ignored", v, 8'h04);
            chk("R10 device still enabled", d_wen, 1'b1);
            rd(2'd2, v); chk("R2 low byte updated", v, 8'hFF);
            // R10 undefined code
            r0 = cs_rises;
            wr(2'd0, 8'h03);
            rd(2'd0, v); chk("R10 bad code status", v, 8'h04);
            repeat (10) @(negedge clk);
            chk("R10 bad code no frame", cs_rises, r0);
            // R9 device never ready
            d_hang = 1'b1;
            expect_word(6'd0, 16'hFFFF);
            wr(2'd0, 8'h02);
            wait_idle(cyc);
            rd(2'd0, v); chk("R9 timeout status", v, 8'h06);
            chk("R9 timeout length", cyc >= TMO, 1'b1);
            chk("R9 cs dropped", ee_cs, 1'b0);
            d_hang = 1'b0;
            // R4 write disable
            wr(2'd0, 8'h04);
            wait_idle(cyc);
            rd(2'd0, v); chk("R4 latch clear", v, 8'h02);
            chk("R4 device disabled", d_wen, 1'b0);
            // R7 again after disable
            r0 = cs_rises;
            wr(2'd0, 8'h02);
            rd(2'd0, v); chk("R7 blocked after disable", v, 8'h02);
            repeat (10) @(negedge clk);
            chk("R7 no frame after disable", cs_rises, r0);
            repeat (5) @(negedge clk);
            chk("R5 scoreboard drained", exp_q.size(), 0);
         end
         begin
            repeat (100000) @(posedge clk);
            chk("watchdog expired", 1, 0);
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule